// File: doc/BRIEF.md
# Audio Output Interrupt Aggregator with Event Decimation

This block collects per-output event pulses from four serial audio lanes and two S/PDIF outputs (buffer underflow, buffer empty, block transfer complete) into one sticky status register and drives a single interrupt line. Software sees three registers: status (write-one-to-clear), enable (same layout as status), and a mode register that holds one rate field per output group.

Each group can be set to raise a status bit on every event, every second event or every fourth event. This cuts the interrupt load when buffers are refilled in large chunks. Each status bit has its own small event counter, and the counter follows the mode field of its group.

Top module: `audio_irq_ctrl`

## Requirements
- R1: After reset, the status, enable and mode registers read 0 and `irq` is low.
- R2: A counted event sets a fixed status bit. Serial lane n underflow sets bit 3-n. S/PDIF n underflow sets bit 7-n. S/PDIF n block complete sets bit 11-n. Serial lane n empty sets bit 19-n. S/PDIF n empty sets bit 23-n. No other input sets a status bit.
- R3: Register select 0 is status, 1 is enable and 2 is mode. Bits outside the layout of R2 always read 0 in status and enable. Only bits 13:12, 17:16 and 21:20 of mode hold a value.
- R4: Writing status with a 1 in a bit that holds 1 clears that bit. Bits written with 0 keep their value.
- R5: If an event sets a status bit in the same cycle that a write clears it, the bit ends up 1.
- R6: The enable register uses the layout of R2. `irq` is high exactly when some status bit and its enable bit are both 1.
- R7: A mode field value of 0 or 3 sets the status bit on every event.
- R8: Mode value 1 sets the status bit on every 2nd event and mode value 2 on every 4th event. Events are counted separately for each status bit.
- R9: Bits 13:12 of mode govern all serial lane bits. Bits 17:16 govern S/PDIF 1. Bits 21:20 govern S/PDIF 0. Each group follows only its own field.
- R10: A write to the mode register clears all event counters. An event in that same cycle is neither counted nor sets status.
- R11: Status bits are set whatever the enable bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register written: 0 status, 1 enable, 2 mode |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register read: 0 status, 1 enable, 2 mode, 3 zero |
| rd_data | output | 32 | Read data, combinational from rd_sel |
| ser_under | input | 4 | Serial lane underflow pulses |
| ser_empty | input | 4 | Serial lane buffer empty pulses |
| spd_under | input | 2 | S/PDIF underflow pulses |
| spd_done | input | 2 | S/PDIF block complete pulses |
| spd_empty | input | 2 | S/PDIF buffer empty pulses |
| irq | output | 1 | Interrupt, OR of enabled status bits |

## Verification
The hardest state to reach is a half-filled event counter that is then discarded. This happens when a mode write lands after one event of a divide-by-two group, or when that write coincides with an event. The stimulus drives a single pulse, rewrites the mode register, and then drives one more pulse. The status bit must still read 0, and it sets only on the second pulse after the rewrite. The bench also drives one event in the same cycle as a clearing write, and runs two bits of one group in parallel to show that their counts stay separate.

// File: rtl/audio_irq_ctrl.sv
module audio_irq_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  input  logic [3:0]  ser_under,
  input  logic [3:0]  ser_empty,
  input  logic [1:0]  spd_under,
  input  logic [1:0]  spd_done,
  input  logic [1:0]  spd_empty,
  output logic        irq
);
  localparam int          NSER     = 4;
  localparam int          NSPD     = 2;
  localparam int          CW       = 2;
  localparam logic [31:0] LIVE     = 32'h00CF_0CCF;
  localparam logic [31:0] MODE_MSK = 32'h0033_3000;

  logic [31:0] ev, hit, clr, st_q, en_q, md_q;
  logic        md_wr;

  assign md_wr = wr_en && (wr_sel == 2'd2);
  assign clr   = (wr_en && wr_sel == 2'd0) ? wr_data : '0;

  always_comb begin
    ev = '0;
    for (int n = 0; n < NSER; n++) begin
      ev[3 - n]  = ser_under[n];
      ev[19 - n] = ser_empty[n];
    end
    for (int n = 0; n < NSPD; n++) begin
      ev[7 - n]  = spd_under[n];
      ev[11 - n] = spd_done[n];
      ev[23 - n] = spd_empty[n];
    end
  end

  for (genvar i = 0; i < 32; i++) begin : g_bit
    if (LIVE[i]) begin : g_cnt
      localparam int SH = (i < 4 || (i >= 16 && i < 20)) ? 12 :
                          (i == 6 || i == 10 || i == 22) ? 16 : 20;
      logic [1:0]    mode;
      logic [CW-1:0] cnt, thr;
      assign mode = md_q[SH +: 2];
      assign thr  = (mode == 2'd1) ? CW'(1) : (mode == 2'd2) ? CW'(3) : CW'(0);
      assign hit[i] = ev[i] && !md_wr && (cnt == thr);
      always_ff @(posedge clk) begin
        if (!rst_n || md_wr)   cnt <= '0;
        else if (hit[i])       cnt <= '0;
        else if (ev[i])        cnt <= cnt + CW'(1);
      end
    end else begin : g_none
      assign hit[i] = ev[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '0;
      en_q <= '0;
      md_q <= '0;
    end else begin
      st_q <= ((st_q & ~clr) | hit) & LIVE;
      if (wr_en && wr_sel == 2'd1) en_q <= wr_data & LIVE;
      if (md_wr)                   md_q <= wr_data & MODE_MSK;
    end
  end

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = st_q;
      2'd1:    rd_data = en_q;
      2'd2:    rd_data = md_q;
      default: rd_data = '0;
    endcase
  end

  assign irq = |(st_q & en_q);
endmodule

// File: rtl/audio_irq_ctrl_chk.sv
module audio_irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic [31:0] wr_data,
  input logic [31:0] ev,
  input logic [31:0] st,
  input logic [31:0] md,
  input logic        irq
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (st == '0 && !irq));

  a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && ev == '0) |=> ((st & $past(wr_data)) == '0));

  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0 && md == '0 && !(wr_en && wr_sel == 2'd2))
      |=> ((st & $past(ev)) == $past(ev)));

  a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((st & ~$past(st) & ~$past(ev)) == '0));

  a_r10_mode_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2) |=> ((st & ~$past(st)) == '0));

  a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(ev) != '0 || $past(wr_en && wr_sel == 2'd1)));
endmodule

bind audio_irq_ctrl audio_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .ev(ev), .st(st_q), .md(md_q), .irq(irq)
);

// File: tb/test_audio_irq_ctrl.sv
module test_audio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic [3:0]  ser_under = '0, ser_empty = '0;
  logic [1:0]  spd_under = '0, spd_done = '0, spd_empty = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [2:0]  q_sel[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  audio_irq_ctrl i_audio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .ser_under(ser_under), .ser_empty(ser_empty),
    .spd_under(spd_under), .spd_done(spd_done), .spd_empty(spd_empty), .irq(irq)
  );

  always @(negedge clk) begin
    if (q_sel.size() != 0) begin
      logic [2:0]  s;
      logic [31:0] e, a;
      string       t;
      s = q_sel.pop_front();
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      a = (s == 3'd4) ? {31'b0, irq} : rd_data;
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", t, s, a, e);
      end
    end
  end

  task automatic drive(input logic [31:0] v);
    for (int n = 0; n < 4; n++) begin
      ser_under[n] = v[3 - n];
      ser_empty[n] = v[19 - n];
    end
    for (int n = 0; n < 2; n++) begin
      spd_under[n] = v[7 - n];
      spd_done[n]  = v[11 - n];
      spd_empty[n] = v[23 - n];
    end
  endtask

  task automatic wr_ev(input logic do_wr, input logic [1:0] s, input logic [31:0] d,
                       input logic [31:0] v);
    @(posedge clk); #1;
    wr_en = do_wr; wr_sel = s; wr_data = d; drive(v);
    @(posedge clk); #1;
    wr_en = 1'b0; drive('0);
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    wr_ev(1'b1, s, d, '0);
  endtask

  task automatic pulse(input logic [31:0] v);
    wr_ev(1'b0, 2'd0, '0, v);
  endtask

  task automatic expect_val(input logic [2:0] s, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    if (s < 3'd4) rd_sel = s[1:0];
    q_sel.push_back(s);
    q_exp.push_back(e);
    q_tag.push_back(t);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1
    expect_val(0, 32'h0, "R1 status");
    expect_val(1, 32'h0, "R1 enable");
    expect_val(2, 32'h0, "R1 mode");
    expect_val(4, 32'h0, "R1 irq");
    // R3
    wr(1, 32'hFFFF_FFFF);
    expect_val(1, 32'h00CF_0CCF, "R3 enable mask");
    wr(2, 32'hFFFF_FFFF);
    expect_val(2, 32'h0033_3000, "R3 mode fields");
    expect_val(3, 32'h0, "R3 unused select");
    wr(2, 32'h0);
    wr(1, 32'h0);
    // R2 / R11
    pulse(32'h0000_0008);
    expect_val(0, 32'h0000_0008, "R2 serial 0 underflow");
    pulse(32'h0002_0000);
    expect_val(0, 32'h0002_0008, "R2 serial 2 empty");
    pulse(32'h0000_0040);
    pulse(32'h0000_0800);
    pulse(32'h0080_0000);
    expect_val(0, 32'h0082_0848, "R2 spdif under/done/empty");
    expect_val(4, 32'h0, "R11 status set with irq disabled");
    // R4
    wr(0, 32'h0082_0800);
    expect_val(0, 32'h0000_0048, "R4 partial clear");
    wr(0, 32'h0);
    expect_val(0, 32'h0000_0048, "R4 zero write no effect");
    wr(0, 32'h0000_0008);
    expect_val(0, 32'h0000_0040, "R4 single clear");
    // R6
    wr(1, 32'h0000_0040);
    expect_val(4, 32'h1, "R6 irq enabled bit");
    wr(1, 32'h0000_0008);
    expect_val(4, 32'h0, "R6 irq other enable");
    wr(1, 32'h0000_0040);
    wr(0, 32'h0000_0040);
    expect_val(4, 32'h0, "R6 irq after clear");
    wr(1, 32'h0);
    // R5
    wr_ev(1'b1, 2'd0, 32'h0000_0008, 32'h0000_0008);
    expect_val(0, 32'h0000_0008, "R5 set beats clear");
    wr(0, 32'h00CF_0CCF);
    expect_val(0, 32'h0, "R4 clear all");
    // R8 / R9
    wr(2, 32'h0020_1000);
    pulse(32'h0000_0004);
    expect_val(0, 32'h0, "R8 div2 first event");
    pulse(32'h0000_0004);
    expect_val(0, 32'h0000_0004, "R8 div2 second event");
    pulse(32'h0080_0000);
    pulse(32'h0080_0000);
    pulse(32'h0080_0000);
    expect_val(0, 32'h0000_0004, "R8 div4 three events");
    pulse(32'h0080_0000);
    expect_val(0, 32'h0080_0004, "R8 div4 fourth event");
    pulse(32'h0000_0040);
    expect_val(0, 32'h0080_0044, "R9 spdif1 every event");
    pulse(32'h0001_0000);
    expect_val(0, 32'h0080_0044, "R9 serial empty under div2");
    pulse(32'h0000_0002);
    expect_val(0, 32'h0080_0044, "R8 per-bit counters separate");
    wr(0, 32'h00CF_0CCF);
    // R7
    wr(2, 32'h0000_3000);
    pulse(32'h0000_0002);
    expect_val(0, 32'h0000_0002, "R7 mode 3 every event");
    wr(2, 32'h0000_0000);
    pulse(32'h0000_0001);
    expect_val(0, 32'h0000_0003, "R7 mode 0 every event");
    wr(0, 32'h00CF_0CCF);
    // R10
    wr(2, 32'h0000_1000);
    pulse(32'h0000_0001);
    wr(2, 32'h0000_1000);
    pulse(32'h0000_0001);
    expect_val(0, 32'h0, "R10 counter cleared by mode write");
    pulse(32'h0000_0001);
    expect_val(0, 32'h0000_0001, "R10 second event after rewrite");
    wr(0, 32'h00CF_0CCF);
    wr_ev(1'b1, 2'd2, 32'h0, 32'h0000_0001);
    expect_val(0, 32'h0, "R10 event during mode write dropped");
    repeat (2) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule